// File: doc/BRIEF.md
# Framed Receive Byte Buffer

This block buffers received frames of variable length for a host to read. Incoming bytes go into a circular byte store, and a frame-end strobe closes each frame. A small table holds one record per frame. Each record gives the number of bytes the frame really kept, plus a flag that is set when some of the frame's bytes were lost because the store was full.

The host sees the oldest frame through a byte window. It places an offset on `rd_offset`, and `rd_data` returns the byte at that position of the head frame one clock later. The host drops the head frame by a write of the release command to the release address. This frees the head frame's bytes in one step. The block reports the bytes held, the frames held, and the length and loss flag of the head frame.

Top module: `frame_rx_buffer`

## Requirements
- R1: A synchronous active-high reset sets `byte_count` and `frame_count` to 0 and sets `head_overrun` to 0.
- R2: Each cycle with `wr_en` high that is not dropped stores `wr_data` and raises `byte_count` by 1 at that clock edge. `byte_count` never exceeds BYTE_DEPTH (default 64).
- R3: Each `frame_end` pulse raises `frame_count` by 1 at that clock edge, including for a frame of zero bytes. `frame_count` equals the frame-record write pointer minus the frame-record read pointer.
- R4: `rd_data` shows the byte stored at (head-frame start + `rd_offset`) modulo BYTE_DEPTH, one clock after `rd_offset` is presented. Offset 0 is the first byte of the oldest frame.
- R5: The head frame is released only by a host write (`host_wr` high) with `host_addr` = 1 and `host_wdata` = 0x04. A write with any other address or data value changes nothing. After a release, `byte_count` and `frame_count` hold their new values within 2 clocks.
- R6: A release moves the window start forward by the head frame's stored length, modulo BYTE_DEPTH. It lowers `byte_count` by that length and `frame_count` by 1.
- R7: A release while `frame_count` is 0 is ignored.
- R8: A byte written while the store holds BYTE_DEPTH bytes is dropped. The record of that frame gets its loss flag set, and the frame still takes a record when it ends.
- R9: The length kept in a frame record (`head_len` when the frame is at the head) counts only the bytes actually stored.
- R10: `head_overrun` is the loss flag of the head frame. It is 0 while no frame is held.
- R11: While the record table holds INFO_DEPTH (default 32) frames, incoming bytes are dropped and `frame_end` is ignored.
- R12: A byte written in the same cycle as `frame_end` belongs to the frame being closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Incoming byte valid |
| wr_data | input | 8 | Incoming byte |
| frame_end | input | 1 | Closes the frame being received |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 8 | Host register address |
| host_wdata | input | 8 | Host write data |
| rd_offset | input | 6 | Byte offset into the head frame |
| rd_data | output | 8 | Byte at the offset, one clock later |
| byte_count | output | 7 | Bytes held in the store |
| frame_count | output | 6 | Frames held |
| head_len | output | 7 | Stored length of the head frame |
| head_overrun | output | 1 | Loss flag of the head frame |

## Verification
The bench uses the default sizes: a 64-byte store and 32 frame records. With these sizes, one 70-byte frame fills the store exactly, drops six bytes, and places its later bytes across the wrap point. The record table can be filled with 32 empty frames in a short run. At these sizes, store-full loss, window reads across the wrap, record-table saturation and releases on an empty buffer all fall within a few thousand cycles.

// File: rtl/frb_pkg.sv
package frb_pkg;
  parameter int unsigned DEF_BYTE_DEPTH = 64;
  parameter int unsigned DEF_INFO_DEPTH = 32;
  parameter int unsigned DEF_DATA_W     = 8;
  parameter int unsigned HOST_ADDR_W    = 8;
  parameter logic [7:0]  RELEASE_ADDR   = 8'd1;
  parameter logic [7:0]  RELEASE_CMD    = 8'h04;
endpackage

// File: rtl/frb_release_dec.sv
module frb_release_dec #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] REL_ADDR = '0,
  parameter logic [DATA_W-1:0] REL_CMD  = '0
) (
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              release_o
);
  always_comb release_o = host_wr && (host_addr == REL_ADDR) && (host_wdata == REL_CMD);
endmodule

// File: rtl/frb_byte_ram.sv
module frb_byte_ram #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/frb_info_table.sv
module frb_info_table #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned LEN_W = 7,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [LEN_W-1:0] wlen,
  input  logic             wovr,
  input  logic [AW-1:0]    raddr,
  output logic [LEN_W-1:0] rlen,
  output logic             rovr
);
  logic [LEN_W-1:0] len_mem [DEPTH];
  logic             ovr_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      len_mem[waddr] <= wlen;
      ovr_mem[waddr] <= wovr;
    end
  end

  always_comb begin
    rlen = len_mem[raddr];
    rovr = ovr_mem[raddr];
  end
endmodule

// File: rtl/frame_rx_buffer.sv
module frame_rx_buffer
  import frb_pkg::*;
#(
  parameter int unsigned BYTE_DEPTH = DEF_BYTE_DEPTH,
  parameter int unsigned INFO_DEPTH = DEF_INFO_DEPTH,
  parameter int unsigned DATA_W     = DEF_DATA_W,
  localparam int unsigned PTR_W  = $clog2(BYTE_DEPTH),
  localparam int unsigned CNT_W  = PTR_W + 1,
  localparam int unsigned IPTR_W = $clog2(INFO_DEPTH),
  localparam int unsigned ICNT_W = IPTR_W + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   frame_end,
  input  logic                   host_wr,
  input  logic [HOST_ADDR_W-1:0] host_addr,
  input  logic [7:0]             host_wdata,
  input  logic [PTR_W-1:0]       rd_offset,
  output logic [DATA_W-1:0]      rd_data,
  output logic [CNT_W-1:0]       byte_count,
  output logic [ICNT_W-1:0]      frame_count,
  output logic [CNT_W-1:0]       head_len,
  output logic                   head_overrun
);
  logic [PTR_W-1:0]  wptr, rptr;
  logic [ICNT_W-1:0] wr_iptr, rd_iptr;
  logic [CNT_W-1:0]  cur_len;
  logic              cur_ovr;
  logic              rel_cmd, byte_full, info_full, store, drop, close, do_rel;
  logic [CNT_W-1:0]  rec_len;
  logic              rec_ovr, tbl_ovr;

  frb_release_dec #(
    .ADDR_W(HOST_ADDR_W), .DATA_W(8),
    .REL_ADDR(RELEASE_ADDR), .REL_CMD(RELEASE_CMD)
  ) u_rel (
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .release_o(rel_cmd)
  );

  always_comb begin
    frame_count = wr_iptr - rd_iptr;
    byte_full   = (byte_count == CNT_W'(BYTE_DEPTH));
    info_full   = (frame_count == ICNT_W'(INFO_DEPTH));
    store       = wr_en && !byte_full && !info_full;
    drop        = wr_en && !store;
    close       = frame_end && !info_full;
    do_rel      = rel_cmd && (frame_count != '0);
    rec_len     = cur_len + CNT_W'(store);
    rec_ovr     = cur_ovr | drop;
    head_overrun = tbl_ovr && (frame_count != '0);
  end

  frb_byte_ram #(.DEPTH(BYTE_DEPTH), .WIDTH(DATA_W)) u_bytes (
    .clk(clk), .we(store), .waddr(wptr), .wdata(wr_data),
    .raddr(rptr + rd_offset), .rdata(rd_data)
  );

  frb_info_table #(.DEPTH(INFO_DEPTH), .LEN_W(CNT_W)) u_info (
    .clk(clk), .we(close), .waddr(wr_iptr[IPTR_W-1:0]),
    .wlen(rec_len), .wovr(rec_ovr),
    .raddr(rd_iptr[IPTR_W-1:0]), .rlen(head_len), .rovr(tbl_ovr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr       <= '0;
      rptr       <= '0;
      wr_iptr    <= '0;
      rd_iptr    <= '0;
      cur_len    <= '0;
      cur_ovr    <= 1'b0;
      byte_count <= '0;
    end else begin
      if (store) wptr <= wptr + 1'b1;
      if (close) begin
        wr_iptr <= wr_iptr + 1'b1;
        cur_len <= '0;
        cur_ovr <= 1'b0;
      end else begin
        cur_len <= rec_len;
        cur_ovr <= rec_ovr;
      end
      if (do_rel) begin
        rd_iptr <= rd_iptr + 1'b1;
        rptr    <= rptr + head_len[PTR_W-1:0];
      end
      byte_count <= byte_count + CNT_W'(store) - (do_rel ? head_len : '0);
    end
  end

  p_byte_bound_r2: assert property (@(posedge clk) disable iff (rst)
    byte_count <= CNT_W'(BYTE_DEPTH));
  p_frame_bound_r3: assert property (@(posedge clk) disable iff (rst)
    frame_count <= ICNT_W'(INFO_DEPTH));
  p_release_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (do_rel && !wr_en) |=> byte_count == $past(byte_count) - $past(head_len));
  p_empty_release_r7: assert property (@(posedge clk) disable iff (rst)
    (rel_cmd && frame_count == '0 && !frame_end) |=> frame_count == '0);
  p_full_overrun_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && byte_full && !info_full && !frame_end) |=> cur_ovr);
  p_head_flag_r10: assert property (@(posedge clk) disable iff (rst)
    (frame_count == '0) |-> !head_overrun);
  p_info_full_r11: assert property (@(posedge clk) disable iff (rst)
    (frame_end && info_full) |=> $stable(wr_iptr));
endmodule

// File: tb/tb_frame_rx_buffer.sv
module tb_frame_rx_buffer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       frame_end = 1'b0;
  logic       host_wr = 1'b0;
  logic [7:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [5:0] rd_offset = '0;
  logic [7:0] rd_data;
  logic [6:0] byte_count, head_len;
  logic [5:0] frame_count;
  logic       head_overrun;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  frame_rx_buffer dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .frame_end(frame_end),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .rd_offset(rd_offset), .rd_data(rd_data), .byte_count(byte_count),
    .frame_count(frame_count), .head_len(head_len), .head_overrun(head_overrun)
  );

  // {frame length, first byte, expected byte_count, expected frame_count}
  localparam logic [31:0] VEC [0:3] = '{
    {8'd3, 8'h10, 8'd3,  8'd1},
    {8'd0, 8'h00, 8'd3,  8'd2},
    {8'd5, 8'h20, 8'd8,  8'd3},
    {8'd8, 8'h30, 8'd16, 8'd4}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_frame(input int n, input logic [7:0] base);
    if (n == 0) begin
      @(negedge clk); frame_end = 1'b1;
      @(posedge clk);
    end else begin
      for (int i = 0; i < n; i++) begin
        @(negedge clk);
        wr_en = 1'b1; wr_data = base + 8'(i); frame_end = (i == n - 1);
        @(posedge clk);
      end
    end
    @(negedge clk); wr_en = 1'b0; frame_end = 1'b0;
  endtask

  task automatic host_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk);
    @(negedge clk); host_wr = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic read_at(input logic [5:0] off, output int val);
    @(negedge clk); rd_offset = off;
    @(posedge clk);
    @(negedge clk); val = rd_data;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    chk("R1 bytes", byte_count, 0);
    chk("R1 frames", frame_count, 0);
    chk("R1 flag", head_overrun, 0);

    // R2 R3 R12 table of frames
    for (int k = 0; k < 4; k++) begin
      push_frame(int'(VEC[k][31:24]), VEC[k][23:16]);
      chk("R2 bytes", byte_count, int'(VEC[k][15:8]));
      chk("R3 frames", frame_count, int'(VEC[k][7:0]));
    end

    // R12 R9 head length includes the byte given with frame_end
    chk("R12 head_len", head_len, 3);
    // R4 window
    read_at(6'd0, v); chk("R4 off0", v, 8'h10);
    read_at(6'd2, v); chk("R4 off2", v, 8'h12);

    // R5 non-matching writes do nothing
    host_write(8'd2, 8'h04);
    host_write(8'd1, 8'h05);
    host_write(8'd1, 8'h00);
    chk("R5 no release bytes", byte_count, 16);
    chk("R5 no release frames", frame_count, 4);
    // R5 R6 release
    host_write(8'd1, 8'h04);
    chk("R6 bytes", byte_count, 13);
    chk("R6 frames", frame_count, 3);
    host_write(8'd1, 8'h04);
    chk("R6 empty frame bytes", byte_count, 13);
    chk("R6 empty frame frames", frame_count, 2);
    chk("R6 head_len", head_len, 5);
    read_at(6'd0, v); chk("R6 window moved", v, 8'h20);
    host_write(8'd1, 8'h04);
    read_at(6'd1, v); chk("R6 window moved 2", v, 8'h31);
    host_write(8'd1, 8'h04);
    chk("R6 all released", byte_count, 0);
    // R7 empty release
    host_write(8'd1, 8'h04);
    chk("R7 frames", frame_count, 0);
    chk("R7 bytes", byte_count, 0);
    chk("R10 flag empty", head_overrun, 0);

    // R8 R9 overrun: start at 16, 70 bytes, 64 kept
    push_frame(70, 8'h40);
    chk("R8 bytes", byte_count, 64);
    chk("R8 frames", frame_count, 1);
    chk("R9 len", head_len, 64);
    chk("R10 flag", head_overrun, 1);
    read_at(6'd0, v);  chk("R4 first", v, 8'h40);
    read_at(6'd47, v); chk("R4 before wrap", v, 8'h6F);
    read_at(6'd48, v); chk("R4 after wrap", v, 8'h70);
    read_at(6'd63, v); chk("R4 last", v, 8'h7F);
    push_frame(2, 8'h90);
    chk("R8 slot taken", frame_count, 2);
    chk("R8 full bytes", byte_count, 64);
    host_write(8'd1, 8'h04);
    chk("R6 big release", byte_count, 0);
    chk("R9 len zero", head_len, 0);
    chk("R10 second flag", head_overrun, 1);
    host_write(8'd1, 8'h04);
    chk("R10 cleared", head_overrun, 0);

    // R11 record table full
    for (int k = 0; k < 32; k++) push_frame(0, 8'h00);
    chk("R11 table full", frame_count, 32);
    push_frame(2, 8'hA0);
    chk("R11 frames", frame_count, 32);
    chk("R11 bytes", byte_count, 0);
    host_write(8'd1, 8'h04);
    chk("R11 after release", frame_count, 31);
    chk("R10 clean head", head_overrun, 0);
    push_frame(1, 8'hB5);
    chk("R11 accepted", frame_count, 32);
    chk("R2 one byte", byte_count, 1);

    // R1 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk("R1 frames again", frame_count, 0);
    chk("R1 bytes again", byte_count, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule